// File: doc/BRIEF.md
# 64-bit Event Timer with One-Shot and Periodic Modes

This block is a 64-bit up-counter with a 64-bit compare value. Software reaches it over a plain 32-bit register bus. It uses the timer to raise a level interrupt after a programmed number of clock cycles. In one-shot mode the timer fires once and then disarms itself. In periodic mode it fires and then restarts from zero on its own.

The bus is 32 bits wide, so the count and the compare value are each split into a low word and a high word. A two-bit arm field selects the operating mode. A separate release register keeps each half of the counter cleared until software lets it go. A match sets a sticky flag. The interrupt output is high while that flag is set and the interrupt is enabled.

Each bus access completes in the cycle it is presented. A write takes effect at the next rising clock edge. Read data is driven combinationally from the current register state. There is no valid/ready handshake and no back-pressure: the block accepts an access on every cycle.

Top module: `evt_timer64`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero. After reset, every mapped address reads zero and `irq` is low.
- R2: The register map is as follows.
  - 0x10: count bits 31:0.
  - 0x14: count bits 63:32.
  - 0x18: compare bits 31:0.
  - 0x1C: compare bits 63:32.
  - 0x20: arm field in bits 7:6; all other bits read zero.
  - 0x24: release field in bits 1:0; all other bits read zero.
  - 0x44: interrupt enable in bit 0 and match flag in bit 1; all other bits read zero.
  - Every other address reads zero, and writes to it have no effect.
- R3: The timer runs when the arm field is 01 or 10 and the release field is 11. While it runs, the 64-bit count increases by one each clock, and the low word carries into the high word.
- R4: While the arm field is 00 or 11, the count holds its value.
- R5: While release bit 0 is zero, the low count word is forced to zero at each edge and writes to it are ignored. Release bit 1 does the same for the high count word. The timer does not run unless both release bits are one.
- R6: At an edge where the timer runs and the count equals the compare value, the match flag (0x44 bit 1) is set.
- R7: In periodic mode (10), the count is zero after a match edge and keeps counting from there. A compare value of zero therefore matches on every edge.
- R8: In one-shot mode (01), the count stays at the match value after a match edge, and the arm field clears itself to 00.
- R9: Writing 0x44 with bit 1 set clears the match flag; writing bit 1 as zero leaves the flag unchanged. If a match occurs at the same edge as a clearing write, the flag stays set.
- R10: `irq` is high exactly while both the match flag and the enable bit (0x44 bit 0) are one.
- R11: A bus write to a count word takes precedence over incrementing or wrapping at the same edge. A write to 0x20 takes precedence over the one-shot self-clear at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write lands at the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench carries the low-to-high carry at 0xFFFFFFFF. A design that dropped the carry would read a high word of zero at the point where it should read one.

It programs a compare value of zero in periodic mode and clears the flag in the same cycle as a match. A clear that wrongly beat the match would lose an event the interrupt should have shown.

It writes the arm field at exactly the edge where a one-shot match would clear it, and writes a count word while counting. A design with the priorities reversed would show a disarmed timer or a count that had incremented past the written value.

It writes to a half that is held by the release field. A design that ignored the release bits would show the written value, or would count without full release.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int OFF_CNT_LO = 'h10;
  localparam int OFF_CNT_HI = 'h14;
  localparam int OFF_CMP_LO = 'h18;
  localparam int OFF_CMP_HI = 'h1C;
  localparam int OFF_ARM    = 'h20;
  localparam int OFF_REL    = 'h24;
  localparam int OFF_INT    = 'h44;
  localparam int ARM_LSB    = 6;

  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_ONCE = 2'b01,
    TM_LOOP = 2'b10,
    TM_RSVD = 2'b11
  } tmode_e;
endpackage

// File: rtl/evt_cnt64.sv
module evt_cnt64 #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            rel,
  input  logic                  run,
  input  logic                  hit,
  input  logic                  wrap,
  input  logic [1:0]            wr_half,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   cnt
);
  localparam int CW = 2 * HALF_W;

  logic [HALF_W-1:0] half_q [2];
  logic [CW-1:0]     nxt;

  assign cnt = {half_q[1], half_q[0]};

  always_comb begin
    nxt = cnt;
    if (run) begin
      if (!hit)
        nxt = cnt + CW'(1);
      else if (wrap)
        nxt = '0;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst || !rel[h])
        half_q[h] <= '0;
      else if (wr_half[h])
        half_q[h] <= wdata;
      else
        half_q[h] <= nxt[h*HALF_W +: HALF_W];
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !hit && wr_half == 2'b00 && rel == 2'b11) |=> cnt == $past(cnt) + CW'(1)); // R3
  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && hit && wrap && wr_half == 2'b00 && rel == 2'b11) |=> cnt == '0); // R7
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && hit && !wrap && wr_half == 2'b00 && rel == 2'b11) |=> $stable(cnt)); // R8
  AST_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !rel[0] |=> half_q[0] == '0); // R5
endmodule

// File: rtl/evt_cfg.sv
module evt_cfg
  import evt_timer_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_clo,
  input  logic                 wr_chi,
  input  logic                 wr_arm,
  input  logic                 wr_rel,
  input  logic [HALF_W-1:0]    wdata,
  input  logic [1:0]           arm_in,
  input  logic [1:0]           rel_in,
  input  logic [2*HALF_W-1:0]  cnt,
  output logic [2*HALF_W-1:0]  cmp,
  output tmode_e               mode,
  output logic [1:0]           rel,
  output logic                 run,
  output logic                 hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      mode <= TM_OFF;
      rel  <= 2'b00;
    end else begin
      if (wr_clo) cmp[HALF_W-1:0]        <= wdata;
      if (wr_chi) cmp[2*HALF_W-1:HALF_W] <= wdata;
      if (wr_rel) rel <= rel_in;
      if (wr_arm)
        mode <= tmode_e'(arm_in);
      else if (hit && mode == TM_ONCE)
        mode <= TM_OFF;
    end
  end

  assign run = (mode == TM_ONCE || mode == TM_LOOP) && rel == 2'b11;
  assign hit = run && (cnt == cmp);

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == TM_ONCE && !wr_arm) |=> mode == TM_OFF); // R8
  AST_ARM_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_arm |=> mode == tmode_e'($past(arm_in))); // R11
  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_RSVD || mode == TM_OFF) |-> !hit); // R4
endmodule

// File: rtl/evt_irq.sv
module evt_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wr,
  input  logic en_in,
  input  logic clr_in,
  output logic en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr) en <= en_in;
      if (hit)
        flag <= 1'b1;
      else if (wr && clr_in)
        flag <= 1'b0;
    end
  end

  assign irq = flag & en;

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr && clr_in)) |=> flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr && clr_in && !hit) |=> !flag); // R9
endmodule

// File: rtl/evt_timer64.sv
module evt_timer64
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CW = 2 * DATA_W;

  logic sel_clo, sel_chi, sel_plo, sel_phi, sel_arm, sel_rel, sel_int;
  logic [CW-1:0] cnt, cmp;
  tmode_e        mode;
  logic [1:0]    rel;
  logic          run, hit, en, flag;

  assign sel_clo = bus_addr == ADDR_W'(OFF_CNT_LO);
  assign sel_chi = bus_addr == ADDR_W'(OFF_CNT_HI);
  assign sel_plo = bus_addr == ADDR_W'(OFF_CMP_LO);
  assign sel_phi = bus_addr == ADDR_W'(OFF_CMP_HI);
  assign sel_arm = bus_addr == ADDR_W'(OFF_ARM);
  assign sel_rel = bus_addr == ADDR_W'(OFF_REL);
  assign sel_int = bus_addr == ADDR_W'(OFF_INT);

  evt_cfg #(.HALF_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_clo (bus_we && sel_plo),
    .wr_chi (bus_we && sel_phi),
    .wr_arm (bus_we && sel_arm),
    .wr_rel (bus_we && sel_rel),
    .wdata  (bus_wdata),
    .arm_in (bus_wdata[ARM_LSB +: 2]),
    .rel_in (bus_wdata[1:0]),
    .cnt    (cnt),
    .cmp    (cmp),
    .mode   (mode),
    .rel    (rel),
    .run    (run),
    .hit    (hit)
  );

  evt_cnt64 #(.HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .rel     (rel),
    .run     (run),
    .hit     (hit),
    .wrap    (mode == TM_LOOP),
    .wr_half ({bus_we && sel_chi, bus_we && sel_clo}),
    .wdata   (bus_wdata),
    .cnt     (cnt)
  );

  evt_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .wr     (bus_we && sel_int),
    .en_in  (bus_wdata[0]),
    .clr_in (bus_wdata[1]),
    .en     (en),
    .flag   (flag),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_clo: bus_rdata = cnt[DATA_W-1:0];
      sel_chi: bus_rdata = cnt[CW-1:DATA_W];
      sel_plo: bus_rdata = cmp[DATA_W-1:0];
      sel_phi: bus_rdata = cmp[CW-1:DATA_W];
      sel_arm: bus_rdata[ARM_LSB +: 2] = mode;
      sel_rel: bus_rdata[1:0] = rel;
      sel_int: bus_rdata[1:0] = {flag, en};
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !irq); // R10
endmodule

// File: tb/sim_evt_timer64.sv
`timescale 1ns/1ps
module sim_evt_timer64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;
  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  evt_timer64 u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rd), .irq(irq)
  );

  // behavioural reference
  logic [63:0] m_cnt, m_cmp;
  logic [1:0]  m_arm, m_rel;
  logic        m_en, m_flag;

  always @(posedge clk) begin : ref_model
    logic going, match;
    logic [63:0] nc;
    if (rst) begin
      m_cnt <= '0; m_cmp <= '0; m_arm <= '0; m_rel <= '0; m_en <= 1'b0; m_flag <= 1'b0;
    end else begin
      going = (m_arm == 2'd1 || m_arm == 2'd2) && m_rel == 2'd3;
      match = going && (m_cnt == m_cmp);
      nc = m_cnt;
      if (going) begin
        if (!match) nc = m_cnt + 64'd1;
        else if (m_arm == 2'd2) nc = 64'd0;
      end
      if (we && addr == 8'h10) nc[31:0] = wd;
      if (we && addr == 8'h14) nc[63:32] = wd;
      if (!m_rel[0]) nc[31:0] = '0;
      if (!m_rel[1]) nc[63:32] = '0;
      m_cnt <= nc;
      if (we && addr == 8'h18) m_cmp[31:0] <= wd;
      if (we && addr == 8'h1C) m_cmp[63:32] <= wd;
      if (we && addr == 8'h20) m_arm <= wd[7:6];
      else if (match && m_arm == 2'd1) m_arm <= 2'd0;
      if (we && addr == 8'h24) m_rel <= wd[1:0];
      if (we && addr == 8'h44) m_en <= wd[0];
      if (match) m_flag <= 1'b1;
      else if (we && addr == 8'h44 && wd[1]) m_flag <= 1'b0;
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_cmp[31:0];
      8'h1C: return m_cmp[63:32];
      8'h20: return {24'd0, m_arm, 6'd0};
      8'h24: return {30'd0, m_rel};
      8'h44: return {30'd0, m_flag, m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(tag, rd, mread(addr));
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_flag & m_en});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wd = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rdchk(string t, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #0.5;
    chk(t, rd, exp);
  endtask

  initial begin
    ticks(2);
    rst = 1'b0;
    // R1 reset state
    tag = "R1";
    rdchk("R1", 8'h10, 0); rdchk("R1", 8'h14, 0); rdchk("R1", 8'h18, 0);
    rdchk("R1", 8'h1C, 0); rdchk("R1", 8'h20, 0); rdchk("R1", 8'h24, 0);
    rdchk("R1", 8'h44, 0); chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 readback and masking
    tag = "R2";
    wr(8'h18, 32'hA5A5_0001); rdchk("R2", 8'h18, 32'hA5A5_0001);
    wr(8'h1C, 32'h0000_0007); rdchk("R2", 8'h1C, 32'h0000_0007);
    wr(8'h20, 32'hFFFF_FFFF); rdchk("R2", 8'h20, 32'h0000_00C0);
    wr(8'h24, 32'hFFFF_FFFF); rdchk("R2", 8'h24, 32'h0000_0003);
    wr(8'h44, 32'h0000_0001); rdchk("R2", 8'h44, 32'h0000_0001);
    wr(8'h30, 32'hFFFF_FFFF); rdchk("R2", 8'h30, 0); rdchk("R2", 8'h00, 0);
    // R4 reserved arm code holds the count
    tag = "R4";
    wr(8'h10, 32'h10); ticks(5); rdchk("R4", 8'h10, 32'h10);
    wr(8'h20, 0); ticks(3); rdchk("R4", 8'h10, 32'h10);
    // R5 release field
    tag = "R5";
    wr(8'h24, 0); tick(); rdchk("R5", 8'h10, 0);
    wr(8'h10, 32'h55); rdchk("R5", 8'h10, 0);
    wr(8'h24, 1); wr(8'h10, 32'h55); rdchk("R5", 8'h10, 32'h55);
    wr(8'h20, 32'h80); ticks(3); rdchk("R5", 8'h10, 32'h55);
    wr(8'h14, 9); rdchk("R5", 8'h14, 0);
    // R7 periodic with compare 3
    tag = "R7";
    wr(8'h20, 0); wr(8'h24, 3); wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h18, 3); wr(8'h1C, 0); wr(8'h44, 3);
    wr(8'h20, 32'h80);
    ticks(3); rdchk("R7", 8'h10, 3); rdchk("R6", 8'h44, 1);
    tick(); rdchk("R7", 8'h10, 0); rdchk("R6", 8'h44, 3);
    chk("R10 irq", {31'd0, irq}, 1);
    tick(); rdchk("R7", 8'h10, 1);
    // R9 flag clearing
    tag = "R9";
    wr(8'h20, 0);
    wr(8'h44, 1); rdchk("R9", 8'h44, 3);
    wr(8'h44, 3); rdchk("R9", 8'h44, 1); chk("R10 irq", {31'd0, irq}, 0);
    wr(8'h44, 2); rdchk("R9", 8'h44, 0);
    wr(8'h18, 0); wr(8'h10, 0); wr(8'h20, 32'h80);
    tag = "R7";
    ticks(4); rdchk("R7", 8'h10, 0);
    tag = "R9";
    wr(8'h44, 2); rdchk("R9", 8'h44, 2);
    // R3 carry and R8 one-shot
    tag = "R3";
    wr(8'h20, 0); wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 0);
    wr(8'h18, 2); wr(8'h1C, 1); wr(8'h44, 2);
    wr(8'h20, 32'h40);
    ticks(2); rdchk("R3", 8'h14, 1); rdchk("R3", 8'h10, 0);
    ticks(2); rdchk("R3", 8'h10, 2); rdchk("R6", 8'h44, 0);
    tag = "R8";
    tick(); rdchk("R6", 8'h44, 2); rdchk("R8", 8'h20, 0); rdchk("R8", 8'h10, 2);
    ticks(3); rdchk("R8", 8'h10, 2); rdchk("R8", 8'h14, 1);
    // R11 write precedence
    tag = "R11";
    wr(8'h10, 0); wr(8'h14, 0); wr(8'h1C, 0); wr(8'h18, 100); wr(8'h20, 32'h80);
    ticks(2); wr(8'h10, 32'h50); rdchk("R11", 8'h10, 32'h50);
    tick(); rdchk("R11", 8'h10, 32'h51);
    wr(8'h20, 0); wr(8'h10, 7); wr(8'h18, 7); wr(8'h20, 32'h40);
    wr(8'h20, 32'h80); rdchk("R11", 8'h20, 32'h80); rdchk("R11", 8'h10, 7);
    tick(); rdchk("R11", 8'h10, 0);
    // mixed traffic against the reference
    tag = "R10";
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 8)
        0: addr = 8'h10; 1: addr = 8'h14; 2: addr = 8'h18; 3: addr = 8'h1C;
        4: addr = 8'h20; 5: addr = 8'h24; 6: addr = 8'h44; default: addr = 8'h3C;
      endcase
      we = ($urandom % 4) == 0;
      wd = (addr == 8'h20) ? {24'd0, 2'($urandom), 6'd0}
         : (addr == 8'h14 || addr == 8'h1C) ? 32'($urandom % 2)
         : (addr == 8'h24) ? (($urandom % 4 == 0) ? 32'd1 : 32'd3)
         : 32'($urandom % 12);
      tick();
      we = 1'b0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule